// File: doc/BRIEF.md
# Register-Set Stack Sequencer

This block saves or restores a group of eight general registers on a memory stack. It does one memory access per cycle. A single start request takes a snapshot of the register values and of the stack pointer. The block then walks the eight slots in a fixed order toward a byte-addressed memory port. In save mode it decrements the stack pointer and then writes. In restore mode it reads and then increments the pointer. Element size is either 2 bytes (narrow form) or 4 bytes (wide form), chosen per operation.

In restore mode, each value read is returned on a register writeback port that carries the slot index. The saved stack-pointer slot is skipped on that port. The final stack pointer is presented once the operation completes, and done pulses for one cycle. Segment and flag registers are not handled.

The memory is assumed to answer reads in the same cycle as the request. The starting stack pointer is assumed aligned to the element size.

Top module: `stk_regset_seq`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o, mem_we_o and wr_en_o are 0, mem_be_o is 0 and sp_o is 0.
- R2: A save performs exactly 8 writes on 8 consecutive cycles, starting the cycle after start_i is accepted. The k-th write carries slot k of regs_i, where slot k is bits [k*32 +: 32]. The slot numbering is 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI.
- R3: On a save, the k-th write (k = 0..7) goes to address SP0 - (k+1)*S, modulo 2^16. SP0 is sp_i at acceptance, and S is 4 when wide_i = 1 and 2 when wide_i = 0.
- R4: On a save, the value written for slot 4 is SP0, zero-extended. The slot-4 field of regs_i is never written.
- R5: In the wide form, mem_be_o is 4'b1111 and mem_wdata_o is the 32-bit element. In the narrow form, the 16-bit element is copied into both halves of mem_wdata_o. mem_be_o is then 4'b0011 when address bit 1 is 0, and 4'b1100 when it is 1.
- R6: When done_o is 1, sp_o equals SP0 - 8*S after a save and SP0 + 8*S after a restore.
- R7: A restore performs 8 reads (mem_we_o = 0) on consecutive cycles. The k-th read is at SP0 + k*S, and wr_idx_o = 7 - k, so DI is restored first and AX last.
- R8: During the read of slot 4, wr_en_o is 0. On every other restore read, wr_en_o is 1.
- R9: On a restore, wr_data_o is the same-cycle mem_rdata_i in the wide form. In the narrow form it is the 16-bit half selected by address bit 1 (bits [31:16] when the bit is 1), zero-extended.
- R10: busy_o is 1 for exactly the 8 access cycles. done_o is a single-cycle pulse in the cycle after the last access.
- R11: start_i is ignored while busy_o is 1. The ongoing sequence's addresses, data and final sp_o are unchanged.
- R12: Changes of regs_i after acceptance do not affect the data written by that save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when not busy |
| pop_i | input | 1 | 0 save, 1 restore (sampled at acceptance) |
| wide_i | input | 1 | 1 selects 4-byte elements, 0 selects 2-byte |
| sp_i | input | AW | Starting stack pointer |
| regs_i | input | 8*DW | Register snapshot, slot k at [k*DW +: DW] |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | AW | Running and final stack pointer |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | DW/8 | Byte enables |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, same cycle |
| wr_en_o | output | 1 | Register writeback valid |
| wr_idx_o | output | 3 | Register slot written back |
| wr_data_o | output | DW | Register writeback value |

## Verification
The hardest situation to reach is a start request, or a change of regs_i, that arrives while a save is still running. The outputs look right whether the block ignores the request or restarts with the same values, so the two cases cannot be told apart unless the inputs differ. The stimulus therefore raises start_i with a different sp_i and inverts every regs_i bit in the middle of each save. It then checks that the remaining addresses and data, and the final pointer, all follow the original request. Every save is followed by a restore from the returned pointer over a modelled memory. The restore is swept over both element sizes and over pointers that cross address zero and both half-word lanes.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  localparam int unsigned NREGS   = 8;
  localparam int unsigned IDXW    = $clog2(NREGS);
  localparam logic [IDXW-1:0] SP_SLOT = IDXW'(4);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/stk_seq_ctl.sv
module stk_seq_ctl
  import stk_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            accept_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [IDXW-1:0] step_o
);
  seq_state_e      state_q;
  logic [IDXW-1:0] step_q;

  // requests during RUN are dropped, not queued
  assign accept_o = start_i && (state_q != ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (accept_o) begin
      state_q <= ST_RUN;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          step_q <= step_q + 1'b1;
          if (step_q == IDXW'(NREGS - 1)) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign step_o = step_q;
endmodule

// File: rtl/stk_seq_sp.sv
module stk_seq_sp #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          adv_i,
  input  logic [AW-1:0] sp_i,
  input  logic          wide_i,
  input  logic          pop_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp0_o,
  output logic          wide_o,
  output logic          pop_o
);
  localparam logic [AW-1:0] STRIDE_W = AW'(DW / 8);
  localparam logic [AW-1:0] STRIDE_N = AW'(DW / 16);

  logic [AW-1:0] sp_q, sp0_q, stride;
  logic          wide_q, pop_q;

  assign stride = wide_q ? STRIDE_W : STRIDE_N;
  // save: pre-decrement; restore: read at current pointer
  assign addr_o = pop_q ? sp_q : sp_q - stride;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      sp0_q  <= '0;
      wide_q <= 1'b0;
      pop_q  <= 1'b0;
    end else if (accept_i) begin
      sp_q   <= sp_i;
      sp0_q  <= sp_i;
      wide_q <= wide_i;
      pop_q  <= pop_i;
    end else if (adv_i) begin
      sp_q <= pop_q ? sp_q + stride : addr_o;
    end
  end

  assign sp_o   = sp_q;
  assign sp0_o  = sp0_q;
  assign wide_o = wide_q;
  assign pop_o  = pop_q;
endmodule

// File: rtl/stk_seq_lane.sv
module stk_seq_lane #(
  parameter int unsigned DW = 32
) (
  input  logic            wide_i,
  input  logic            hi_i,
  input  logic [DW-1:0]   elem_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0]   wdata_o,
  output logic [DW-1:0]   relem_o
);
  localparam int unsigned HW = DW / 2;
  localparam int unsigned HB = DW / 16;

  logic [HW-1:0] rhalf;

  assign rhalf = hi_i ? rdata_i[DW-1:HW] : rdata_i[HW-1:0];

  always_comb begin
    if (wide_i) begin
      be_o    = '1;
      wdata_o = elem_i;
      relem_o = rdata_i;
    end else begin
      be_o    = hi_i ? {{HB{1'b1}}, {HB{1'b0}}} : {{HB{1'b0}}, {HB{1'b1}}};
      wdata_o = {elem_i[HW-1:0], elem_i[HW-1:0]};
      relem_o = {{HW{1'b0}}, rhalf};
    end
  end
endmodule

// File: rtl/stk_regset_seq.sv
module stk_regset_seq
  import stk_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                pop_i,
  input  logic                wide_i,
  input  logic [AW-1:0]       sp_i,
  input  logic [NREGS*DW-1:0] regs_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [AW-1:0]       sp_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DW/8-1:0]     mem_be_o,
  output logic [DW-1:0]       mem_wdata_o,
  input  logic [DW-1:0]       mem_rdata_i,
  output logic                wr_en_o,
  output logic [IDXW-1:0]     wr_idx_o,
  output logic [DW-1:0]       wr_data_o
);
  localparam int unsigned BEW  = DW / 8;
  localparam int unsigned HSEL = $clog2(DW / 16);

  logic            accept, busy, pop_q, wide_q;
  logic [IDXW-1:0] step, idx;
  logic [AW-1:0]   addr, sp0;
  logic [DW-1:0]   elem, lane_wdata, lane_relem;
  logic [BEW-1:0]  lane_be;
  logic [DW-1:0]   snap_q [NREGS];

  stk_seq_ctl i_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .done_o   (done_o),
    .step_o   (step)
  );

  stk_seq_sp #(.AW(AW), .DW(DW)) i_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .adv_i    (busy),
    .sp_i     (sp_i),
    .wide_i   (wide_i),
    .pop_i    (pop_i),
    .addr_o   (addr),
    .sp_o     (sp_o),
    .sp0_o    (sp0),
    .wide_o   (wide_q),
    .pop_o    (pop_q)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                snap_q[g] <= '0;
      else if (accept && !pop_i)  snap_q[g] <= regs_i[g*DW +: DW];
    end
  end

  // restore walks the slots backwards
  assign idx  = pop_q ? (IDXW'(NREGS - 1) - step) : step;
  assign elem = (idx == SP_SLOT) ? DW'(sp0) : snap_q[idx];

  stk_seq_lane #(.DW(DW)) i_lane (
    .wide_i  (wide_q),
    .hi_i    (addr[HSEL]),
    .elem_i  (elem),
    .rdata_i (mem_rdata_i),
    .be_o    (lane_be),
    .wdata_o (lane_wdata),
    .relem_o (lane_relem)
  );

  assign busy_o      = busy;
  assign mem_req_o   = busy;
  assign mem_we_o    = busy && !pop_q;
  assign mem_addr_o  = addr;
  assign mem_be_o    = busy ? lane_be : '0;
  assign mem_wdata_o = mem_we_o ? lane_wdata : '0;
  assign wr_en_o     = busy && pop_q && (idx != SP_SLOT);
  assign wr_idx_o    = idx;
  assign wr_data_o   = wr_en_o ? lane_relem : '0;
endmodule

// File: rtl/stk_regset_seq_chk.sv
module stk_regset_seq_chk
  import stk_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW/8-1:0] mem_be_o,
  input logic            wr_en_o
);
  localparam int unsigned HSEL = $clog2(DW / 16);
  localparam int unsigned HB   = DW / 16;

  logic [IDXW:0] run_cnt;
  logic [AW-1:0] stride;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  assign stride = (mem_be_o == '1) ? AW'(DW / 8) : AW'(DW / 16);

  p_busy_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_cnt == (IDXW+1)'(NREGS)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_push_descend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - stride));

  p_pop_ascend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o && $past(busy_o) && !$past(mem_we_o))
      |-> (mem_addr_o == $past(mem_addr_o) + stride));

  p_half_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_be_o != '1) |->
      (mem_be_o == (mem_addr_o[HSEL] ? {{HB{1'b1}}, {HB{1'b0}}} : {{HB{1'b0}}, {HB{1'b1}}})));

  p_wb_on_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (mem_req_o && !mem_we_o));

  p_mode_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_we_o));
endmodule

bind stk_regset_seq stk_regset_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .wr_en_o    (wr_en_o)
);

// File: tb/test_stk_regset_seq.sv
module test_stk_regset_seq;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, pop_i = 1'b0, wide_i = 1'b0;
  logic [15:0]   sp_i = '0;
  logic [255:0]  regs_i = '0;
  logic          busy_o, done_o, mem_req_o, mem_we_o, wr_en_o;
  logic [15:0]   sp_o, mem_addr_o;
  logic [3:0]    mem_be_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i, wr_data_o;
  logic [2:0]    wr_idx_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [256];
  logic [31:0] exp_reg [8];
  logic [7:0]  rbase;

  always #2 clk_i = ~clk_i;

  stk_regset_seq #(.AW(AW), .DW(DW)) i_stk_regset_seq (.*);

  assign rbase = {mem_addr_o[7:2], 2'b00};
  assign mem_rdata_i = {mem[rbase + 8'd3], mem[rbase + 8'd2], mem[rbase + 8'd1], mem[rbase]};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int seed, input int k);
    return (32'(seed) * 32'h9E3779B1) ^ (32'(k) * 32'h01230457) ^ 32'(k);
  endfunction

  task automatic do_push(input bit wide, input logic [15:0] sp0, input int seed, output logic [15:0] sp_end);
    logic [15:0] s, a;
    logic [31:0] e, wd;
    logic [3:0]  be;
    s = wide ? 16'd4 : 16'd2;
    for (int k = 0; k < 8; k++) begin
      exp_reg[k] = pat(seed, k);
      regs_i[k*32 +: 32] = exp_reg[k];
    end
    start_i = 1'b1; pop_i = 1'b0; wide_i = wide; sp_i = sp0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      a = sp0 - 16'(k + 1) * s;
      e = (k == 4) ? {16'h0, sp0} : exp_reg[k];
      if (wide) begin wd = e; be = 4'hF; end
      else begin wd = {e[15:0], e[15:0]}; be = a[1] ? 4'b1100 : 4'b0011; end
      chk(busy_o && mem_req_o && mem_we_o, "R2 write cycle", {busy_o, mem_req_o, mem_we_o}, 3'b111);
      chk(mem_addr_o == a, "R3 push address", mem_addr_o, a);
      if (k == 4) chk(mem_wdata_o == wd, "R4 sp slot value", mem_wdata_o, wd);
      else if (k > 2) chk(mem_wdata_o == wd, "R12 snapshot data", mem_wdata_o, wd);
      else chk(mem_wdata_o == wd, "R2 slot data", mem_wdata_o, wd);
      chk(mem_be_o == be, "R5 byte enables", mem_be_o, be);
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[{mem_addr_o[7:2], 2'b00} + 8'(b)] = mem_wdata_o[b*8 +: 8];
      if (k == 2) begin
        start_i = 1'b1; sp_i = 16'h5A5A; pop_i = 1'b1; wide_i = ~wide; regs_i = ~regs_i;
      end
      if (k == 3) start_i = 1'b0;
      @(negedge clk_i);
    end
    chk(done_o && !busy_o && !mem_req_o, "R10 done after last", {done_o, busy_o, mem_req_o}, 3'b100);
    chk(sp_o == sp0 - 16'd8 * s, "R6 R11 final sp push", sp_o, sp0 - 16'd8 * s);
    sp_end = sp_o;
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R10 done single pulse", {done_o, busy_o}, 2'b00);
  endtask

  task automatic do_pop(input bit wide, input logic [15:0] sp0);
    logic [15:0] s, a;
    logic [31:0] e;
    int idx;
    s = wide ? 16'd4 : 16'd2;
    start_i = 1'b1; pop_i = 1'b1; wide_i = wide; sp_i = sp0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      idx = 7 - k;
      a = sp0 + 16'(k) * s;
      chk(busy_o && mem_req_o && !mem_we_o, "R7 read cycle", {busy_o, mem_req_o, mem_we_o}, 3'b110);
      chk(mem_addr_o == a, "R7 pop address", mem_addr_o, a);
      chk(wr_idx_o == 3'(idx), "R7 pop order", wr_idx_o, idx);
      chk(wr_en_o == (idx != 4), "R8 sp slot discarded", wr_en_o, idx != 4);
      if (idx != 4) begin
        e = wide ? exp_reg[idx] : {16'h0, exp_reg[idx][15:0]};
        chk(wr_data_o == e, "R9 restored value", wr_data_o, e);
      end
      @(negedge clk_i);
    end
    chk(done_o && !busy_o, "R10 done after restore", {done_o, busy_o}, 2'b10);
    chk(sp_o == sp0 + 16'd8 * s, "R6 R8 final sp pop", sp_o, sp0 + 16'd8 * s);
    @(negedge clk_i);
    chk(!done_o, "R10 done single pulse", done_o, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] sp_list [4];
    logic [15:0] sp0, sp_end;
    int seed;
    sp_list[0] = 16'h0100; sp_list[1] = 16'h0046;
    sp_list[2] = 16'h000C; sp_list[3] = 16'h0002;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !mem_we_o && !wr_en_o, "R1 reset outputs",
        {busy_o, done_o, mem_req_o, mem_we_o, wr_en_o}, 0);
    chk(mem_be_o == 4'h0 && sp_o == 16'h0, "R1 reset be and sp", {mem_be_o, sp_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && sp_o == 16'h0, "R1 idle after reset", {busy_o, sp_o}, 0);
    seed = 1;
    for (int w = 0; w < 2; w++) begin
      for (int j = 0; j < 4; j++) begin
        sp0 = sp_list[j] & (w != 0 ? 16'hFFFC : 16'hFFFE);
        do_push(w != 0, sp0, seed, sp_end);
        do_pop(w != 0, sp_end);
        seed++;
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule